// File: doc/BRIEF.md
# Transceiver Reconfiguration Sequencing Controller

This controller sits between user logic and a group of serial transceiver channels. It orders all reconfiguration traffic to them. After reset it first runs a calibration sweep. The sweep visits every attached receiver channel in turn: it gives each one a start strobe and waits for that channel's done flag. Only after the sweep does it take user commands.

There are two access modes, picked by a level input.

- **Image-write mode.** A single-cycle `write_all` pulse copies configuration words from an external word memory into the selected channel. The memory answers a fixed number of cycles after each read, and the controller aligns the returned data to that latency.
  - In continuous mode one pulse moves the whole image, one word per cycle.
  - In per-word mode each pulse moves one word, taken from an internal pointer that wraps at the end of the image.
- **Analog-control access mode.** A `write_all` pulse does a single register write into the selected channel. A `read` pulse does a register read, which ends with a one-cycle `data_valid` strobe.

A request the controller cannot serve leaves `busy` low and raises `error` for exactly two cycles. Requests that arrive while the controller is occupied are dropped.

Top module: `xrs_reconf_ctrl`

## Requirements
- R1: While reset is applied, and for the first cycle after the internal reset release (two clock edges after `rst_n` rises), `busy` is 0. On the cycle after that, `busy` is 1 and calibration starts.
- R2: Calibration visits channels in ascending index order. `cal_start[i]` is a one-cycle strobe, with at most one bit set. The controller waits for `cal_done[i]` (done flags of other channels do not count) and then strobes channel i+1 in the next cycle.
- R3: `busy` falls in the cycle after the cycle in which the last channel's `cal_done` is seen, and stays low while no command runs.
- R4: In image-write mode (`analog_mode`=0) with `cont_mode`=1, one `write_all` pulse reads memory addresses 0 to IMG_WORDS-1 in consecutive cycles, starting the next cycle. Word j is written to the channel (`ch_wr`=1, `ch_addr`=j, `ch_wdata`=memory data) exactly MEM_LAT cycles after its read.
- R5: In image-write mode with `cont_mode`=0, each `write_all` pulse reads and writes one word at the word pointer. The pointer starts at 0 after reset, advances by one per pulse, and wraps from IMG_WORDS-1 to 0. Continuous writes leave it unchanged.
- R6: `busy` is 1 from the cycle after `write_all` through the last channel write of an image transfer, and falls in the next cycle. No channel write happens while the controller is idle.
- R7: In analog-control mode (`analog_mode`=1), a `write_all` pulse gives, in the next cycle, one `ch_wr` cycle with `busy`=1, `ch_addr`=`reg_addr` and `ch_wdata`=`wr_data`, to channel `ch_sel`.
- R8: In analog-control mode, a `read` pulse holds `ch_rd` (and `busy`) from the next cycle up to and including the cycle in which `ch_ack` is high. In the following cycle `data_valid` is 1 for exactly one cycle with `rd_data`=`ch_rdata`, and `busy` falls in that same cycle.
- R9: `write_all` and `read` are ignored during calibration, while `busy` is 1, and during the error pulse.
- R10: A `read` in image-write mode, or `read` and `write_all` in the same cycle, is unsupported. In the next two cycles `error` is 1 and `busy` is 0, after which `error` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| write_all | input | 1 | Single-cycle write request |
| read | input | 1 | Single-cycle read request |
| analog_mode | input | 1 | 1 = analog-control access, 0 = image write |
| cont_mode | input | 1 | 1 = continuous image write, 0 = per-word |
| ch_sel | input | CH_W | Target channel for the next command |
| reg_addr | input | AW | Register address for analog-control access |
| wr_data | input | DW | Write data for analog-control access |
| busy | output | 1 | Calibration or transaction in progress |
| data_valid | output | 1 | One-cycle strobe qualifying rd_data |
| error | output | 1 | Unsupported request, two-cycle pulse |
| rd_data | output | DW | Read result |
| mem_rd | output | 1 | Word memory read request |
| mem_addr | output | AW | Word memory address |
| mem_data | input | DW | Word memory data, MEM_LAT cycles after mem_rd |
| cal_start | output | NUM_CH | Per-channel calibration start strobes |
| cal_done | input | NUM_CH | Per-channel calibration done flags |
| ch_idx | output | CH_W | Channel addressed by ch_wr / ch_rd |
| ch_wr | output | 1 | Channel register write |
| ch_rd | output | 1 | Channel register read, held until ch_ack |
| ch_addr | output | AW | Channel register address |
| ch_wdata | output | DW | Channel write data |
| ch_rdata | input | DW | Channel read data, valid with ch_ack |
| ch_ack | input | 1 | Channel read acknowledge |

## Verification
The assertions assume the following about the environment:
- The memory returns data exactly MEM_LAT cycles after each read.
- A channel raises `ch_ack` only while `ch_rd` is held.
- `cal_done[i]` is meaningful only after that channel's strobe.

The stimulus follows these rules. Memory is modelled as a MEM_LAT-stage delay line. Acknowledges come only during a pending read, with delays of zero and several cycles. Done flags are given only while a channel is being waited on; a mismatched set of done bits is shown first to check the ordering. Mode and channel-select levels change only between commands.

// File: rtl/xrs_pkg.sv
`timescale 1ns/1ps
package xrs_pkg;

  typedef enum logic [1:0] {
    CAL_PWR,
    CAL_STRB,
    CAL_WAIT,
    CAL_FIN
  } cal_state_e;

  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_IMG,
    CMD_DRAIN,
    CMD_AWR,
    CMD_ARD,
    CMD_ERR1,
    CMD_ERR2
  } cmd_state_e;

endpackage

// File: rtl/xrs_cal_sweep.sv
`timescale 1ns/1ps
module xrs_cal_sweep
  import xrs_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] cal_done,
  output logic [NUM_CH-1:0] cal_start,
  output logic              cal_busy,
  output logic              cal_ready
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  cal_state_e      state_q, state_d;
  logic [CH_W-1:0] idx_q, idx_d;
  logic            idx_en;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    unique case (state_q)
      CAL_PWR:  state_d = CAL_STRB;
      CAL_STRB: state_d = CAL_WAIT;
      CAL_WAIT: begin
        if (cal_done[idx_q]) begin
          if (idx_q == LAST_CH) begin
            state_d = CAL_FIN;
          end else begin
            state_d = CAL_STRB;
            idx_d   = idx_q + CH_W'(1);
            idx_en  = 1'b1;
          end
        end
      end
      default:  state_d = CAL_FIN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CAL_PWR;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_strb
    assign cal_start[g] = (state_q == CAL_STRB) && (idx_q == CH_W'(g));
  end

  assign cal_busy  = (state_q == CAL_STRB) || (state_q == CAL_WAIT);
  assign cal_ready = (state_q == CAL_FIN);

  AST_CAL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(cal_start));                                            // R2
  AST_CAL_STRB_ONE: assert property (@(posedge clk) disable iff (!rst_ni)
    (cal_start != '0) |=> (cal_start == '0));                        // R2
  AST_CAL_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    cal_ready |=> (cal_ready && !cal_busy));                         // R3

endmodule

// File: rtl/xrs_mem_align.sv
`timescale 1ns/1ps
module xrs_mem_align #(
  parameter int LAT = 2,
  parameter int AW  = 6
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic          out_vld,
  output logic [AW-1:0] out_addr,
  output logic          tail_clear
);

  logic [LAT-1:0] vld_q;
  logic [AW-1:0]  addr_q [LAT];

  assign mem_rd   = issue;
  assign mem_addr = issue_addr;

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    logic          v_in;
    logic [AW-1:0] a_in;
    if (s == 0) begin : g_head
      assign v_in = issue;
      assign a_in = issue_addr;
    end else begin : g_body
      assign v_in = vld_q[s-1];
      assign a_in = addr_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s]  <= 1'b0;
        addr_q[s] <= '0;
      end else begin
        vld_q[s] <= v_in;
        if (v_in) addr_q[s] <= a_in;
      end
    end
  end

  assign out_vld  = vld_q[LAT-1];
  assign out_addr = addr_q[LAT-1];

  if (LAT == 1) begin : g_tail1
    assign tail_clear = 1'b1;
  end else begin : g_tailn
    assign tail_clear = ~|vld_q[LAT-2:0];
  end

  AST_ALIGN_TAIL: assert property (@(posedge clk) disable iff (!rst_ni)
    (tail_clear && !issue) |=> !(|vld_q[LAT-1:0] && !out_vld));     // R4

endmodule

// File: rtl/xrs_reconf_ctrl.sv
`timescale 1ns/1ps
module xrs_reconf_ctrl
  import xrs_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int AW        = 6,
  parameter int DW        = 16,
  parameter int IMG_WORDS = 8,
  parameter int MEM_LAT   = 2,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              write_all,
  input  logic              read,
  input  logic              analog_mode,
  input  logic              cont_mode,
  input  logic [CH_W-1:0]   ch_sel,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              busy,
  output logic              data_valid,
  output logic              error,
  output logic [DW-1:0]     rd_data,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [DW-1:0]     mem_data,
  output logic [NUM_CH-1:0] cal_start,
  input  logic [NUM_CH-1:0] cal_done,
  output logic [CH_W-1:0]   ch_idx,
  output logic              ch_wr,
  output logic              ch_rd,
  output logic [AW-1:0]     ch_addr,
  output logic [DW-1:0]     ch_wdata,
  input  logic [DW-1:0]     ch_rdata,
  input  logic              ch_ack
);

  localparam logic [AW-1:0] LAST_W = AW'(IMG_WORDS - 1);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  logic cal_busy, cal_ready;
  xrs_cal_sweep #(.NUM_CH(NUM_CH)) u_cal (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .cal_done  (cal_done),
    .cal_start (cal_start),
    .cal_busy  (cal_busy),
    .cal_ready (cal_ready)
  );

  cmd_state_e      state_q, state_d;
  logic [AW-1:0]   cnt_q, cnt_d;
  logic [AW-1:0]   wptr_q, wptr_d;
  logic [CH_W-1:0] sel_q;
  logic [AW-1:0]   reg_q;
  logic [DW-1:0]   wd_q;
  logic            cont_q;
  logic            dv_q, dv_d;
  logic [DW-1:0]   rd_q;
  logic            cap_en, cnt_en, wptr_en, rd_en;
  logic            issue, out_vld, tail_clear;
  logic [AW-1:0]   out_addr;
  logic            accept, bad_req;

  xrs_mem_align #(.LAT(MEM_LAT), .AW(AW)) u_align (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .issue      (issue),
    .issue_addr (cnt_q),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .out_vld    (out_vld),
    .out_addr   (out_addr),
    .tail_clear (tail_clear)
  );

  assign accept  = cal_ready && (state_q == CMD_IDLE);
  assign bad_req = read && (write_all || !analog_mode);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wptr_d  = wptr_q;
    cap_en  = 1'b0;
    cnt_en  = 1'b0;
    wptr_en = 1'b0;
    rd_en   = 1'b0;
    dv_d    = 1'b0;
    issue   = 1'b0;
    unique case (state_q)
      CMD_IDLE: begin
        if (accept && (read || write_all)) begin
          cap_en = 1'b1;
          if (bad_req) begin
            state_d = CMD_ERR1;
          end else if (read) begin
            state_d = CMD_ARD;
          end else if (analog_mode) begin
            state_d = CMD_AWR;
          end else begin
            state_d = CMD_IMG;
            cnt_en  = 1'b1;
            cnt_d   = cont_mode ? '0 : wptr_q;
          end
        end
      end
      CMD_IMG: begin
        issue = 1'b1;
        if (cont_q) begin
          if (cnt_q == LAST_W) begin
            state_d = CMD_DRAIN;
          end else begin
            cnt_en = 1'b1;
            cnt_d  = cnt_q + AW'(1);
          end
        end else begin
          wptr_en = 1'b1;
          wptr_d  = (wptr_q == LAST_W) ? '0 : wptr_q + AW'(1);
          state_d = CMD_DRAIN;
        end
      end
      CMD_DRAIN: if (tail_clear) state_d = CMD_IDLE;
      CMD_AWR:   state_d = CMD_IDLE;
      CMD_ARD: begin
        if (ch_ack) begin
          state_d = CMD_IDLE;
          dv_d    = 1'b1;
          rd_en   = 1'b1;
        end
      end
      CMD_ERR1:  state_d = CMD_ERR2;
      default:   state_d = CMD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CMD_IDLE;
      cnt_q   <= '0;
      wptr_q  <= '0;
      sel_q   <= '0;
      reg_q   <= '0;
      wd_q    <= '0;
      cont_q  <= 1'b0;
      dv_q    <= 1'b0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      dv_q    <= dv_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (wptr_en) wptr_q <= wptr_d;
      if (rd_en)   rd_q   <= ch_rdata;
      if (cap_en) begin
        sel_q  <= ch_sel;
        reg_q  <= reg_addr;
        wd_q   <= wr_data;
        cont_q <= cont_mode;
      end
    end
  end

  logic cmd_busy, reg_acc;
  assign cmd_busy = (state_q == CMD_IMG) || (state_q == CMD_DRAIN) ||
                    (state_q == CMD_AWR) || (state_q == CMD_ARD);
  assign reg_acc  = (state_q == CMD_AWR) || (state_q == CMD_ARD);

  assign busy       = cal_busy || cmd_busy;
  assign error      = (state_q == CMD_ERR1) || (state_q == CMD_ERR2);
  assign data_valid = dv_q;
  assign rd_data    = rd_q;
  assign ch_idx     = sel_q;
  assign ch_wr      = out_vld || (state_q == CMD_AWR);
  assign ch_rd      = (state_q == CMD_ARD);
  assign ch_addr    = reg_acc ? reg_q : out_addr;
  assign ch_wdata   = (state_q == CMD_AWR) ? wd_q : mem_data;

  AST_ERR_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    error |-> !busy);                                                // R10
  AST_ERR_TWO: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(error) |=> error);                                         // R10
  AST_ERR_END: assert property (@(posedge clk) disable iff (!rst_ni)
    (error && $past(error)) |=> !error);                             // R10
  AST_DV_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_ni)
    data_valid |-> (!busy && $past(busy)));                          // R8
  AST_DV_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    data_valid |=> !data_valid);                                     // R8
  AST_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    ch_wr |-> busy);                                                 // R6
  AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == CMD_IDLE) |-> !ch_wr);                               // R6
  AST_CMD_AFTER_CAL: assert property (@(posedge clk) disable iff (!rst_ni)
    cal_busy |-> (state_q == CMD_IDLE));                             // R9

endmodule

// File: tb/xrs_reconf_ctrl_test.sv
`timescale 1ns/1ps
module xrs_reconf_ctrl_test;

  localparam int NUM_CH = 4;
  localparam int AW     = 6;
  localparam int DW     = 16;
  localparam int NW     = 8;
  localparam int LAT    = 2;
  localparam int CH_W   = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n, write_all, read, analog_mode, cont_mode;
  logic [CH_W-1:0]   ch_sel;
  logic [AW-1:0]     reg_addr;
  logic [DW-1:0]     wr_data;
  logic              busy, data_valid, error;
  logic [DW-1:0]     rd_data;
  logic              mem_rd;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_data;
  logic [NUM_CH-1:0] cal_start, cal_done;
  logic [CH_W-1:0]   ch_idx;
  logic              ch_wr, ch_rd, ch_ack;
  logic [AW-1:0]     ch_addr;
  logic [DW-1:0]     ch_wdata, ch_rdata;

  xrs_reconf_ctrl #(
    .NUM_CH(NUM_CH), .AW(AW), .DW(DW), .IMG_WORDS(NW), .MEM_LAT(LAT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .write_all(write_all), .read(read),
    .analog_mode(analog_mode), .cont_mode(cont_mode), .ch_sel(ch_sel),
    .reg_addr(reg_addr), .wr_data(wr_data), .busy(busy),
    .data_valid(data_valid), .error(error), .rd_data(rd_data),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
    .cal_start(cal_start), .cal_done(cal_done), .ch_idx(ch_idx),
    .ch_wr(ch_wr), .ch_rd(ch_rd), .ch_addr(ch_addr), .ch_wdata(ch_wdata),
    .ch_rdata(ch_rdata), .ch_ack(ch_ack)
  );

  function automatic logic [DW-1:0] img(input int a);
    return DW'(16'hA5C3) ^ (DW'(a) * DW'(16'h0107));
  endfunction

  // word memory: LAT-stage delay line
  logic [LAT-1:0] mv;
  logic [AW-1:0]  ma [LAT];
  always_ff @(posedge clk) begin
    if (!rst_n) mv <= '0;
    else begin
      mv[0] <= mem_rd;
      for (int i = 1; i < LAT; i++) mv[i] <= mv[i-1];
    end
    ma[0] <= mem_addr;
    for (int i = 1; i < LAT; i++) ma[i] <= ma[i-1];
  end
  assign mem_data = mv[LAT-1] ? img(int'(ma[LAT-1])) : '0;

  int total = 0;
  int bad   = 0;

  logic              e_busy, e_err, e_dv, e_wr, e_rd, e_mrd;
  logic [NUM_CH-1:0] e_cal;
  int                e_maddr, e_caddr, e_wdata, e_idx, e_rdata;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic clear_exp();
    e_busy = 0; e_err = 0; e_dv = 0; e_wr = 0; e_rd = 0; e_mrd = 0;
    e_cal = '0; e_maddr = 0; e_caddr = 0; e_wdata = 0; e_idx = 0; e_rdata = 0;
  endtask

  // compare this cycle, then step to the next one
  task automatic cyc(input string tag);
    #2;
    chk(tag, "busy", int'(busy), int'(e_busy));
    chk(tag, "error", int'(error), int'(e_err));
    chk(tag, "data_valid", int'(data_valid), int'(e_dv));
    chk(tag, "cal_start", int'(cal_start), int'(e_cal));
    chk(tag, "ch_wr", int'(ch_wr), int'(e_wr));
    chk(tag, "ch_rd", int'(ch_rd), int'(e_rd));
    chk(tag, "mem_rd", int'(mem_rd), int'(e_mrd));
    if (e_mrd) chk(tag, "mem_addr", int'(mem_addr), e_maddr);
    if (e_wr) begin
      chk(tag, "ch_addr", int'(ch_addr), e_caddr);
      chk(tag, "ch_wdata", int'(ch_wdata), e_wdata);
      chk(tag, "ch_idx", int'(ch_idx), e_idx);
    end
    if (e_rd) begin
      chk(tag, "ch_addr", int'(ch_addr), e_caddr);
      chk(tag, "ch_idx", int'(ch_idx), e_idx);
    end
    if (e_dv) chk(tag, "rd_data", int'(rd_data), e_rdata);
    @(posedge clk);
    #1;
    clear_exp();
    write_all = 0; read = 0; cal_done = '0; ch_ack = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; write_all = 0; read = 0; analog_mode = 0; cont_mode = 1;
    ch_sel = 0; reg_addr = 0; wr_data = 0; cal_done = '0; ch_ack = 0;
    ch_rdata = 0;
    clear_exp();
    // R1: reset state
    repeat (3) cyc("R1");
    rst_n = 1;
    repeat (3) cyc("R1");

    // R2/R3 calibration sweep; R9 request during sweep
    for (int i = 0; i < NUM_CH; i++) begin
      e_busy = 1; e_cal = NUM_CH'(1) << i; cyc("R2");
      e_busy = 1; cal_done = ~(NUM_CH'(1) << i); cyc("R2");
      for (int w = 0; w < i; w++) begin
        e_busy = 1;
        if (i == 1) write_all = 1;
        cyc("R9");
      end
      e_busy = 1; cal_done = NUM_CH'(1) << i; cyc("R2");
    end
    cyc("R3");
    cyc("R3");

    // R4/R6 continuous image write to channel 2; R9 read while busy
    analog_mode = 0; cont_mode = 1; ch_sel = 2;
    write_all = 1; cyc("R4");
    for (int k = 1; k <= NW + LAT; k++) begin
      e_busy = 1;
      if (k == 3) read = 1;
      if (k <= NW) begin e_mrd = 1; e_maddr = k - 1; end
      if (k > LAT) begin
        e_wr = 1; e_caddr = k - 1 - LAT; e_wdata = int'(img(k - 1 - LAT)); e_idx = 2;
      end
      cyc("R4");
    end
    cyc("R6");
    cyc("R6");

    // R5 per-word writes with pointer wrap
    cont_mode = 0; ch_sel = 1;
    for (int n = 0; n <= NW; n++) begin
      write_all = 1; cyc("R5");
      for (int k = 1; k <= 1 + LAT; k++) begin
        e_busy = 1;
        if (k == 1) begin e_mrd = 1; e_maddr = n % NW; end
        if (k == 1 + LAT) begin
          e_wr = 1; e_caddr = n % NW; e_wdata = int'(img(n % NW)); e_idx = 1;
        end
        cyc("R5");
      end
    end
    cyc("R6");

    // R7 analog register write
    analog_mode = 1; ch_sel = 3; reg_addr = 6'h2A; wr_data = 16'hBEEF;
    write_all = 1; cyc("R7");
    e_busy = 1; e_wr = 1; e_caddr = 'h2A; e_wdata = 'hBEEF; e_idx = 3; cyc("R7");
    cyc("R7");

    // R8 analog read with delayed ack; R9 read during transaction
    ch_sel = 0; reg_addr = 6'h15;
    read = 1; cyc("R8");
    for (int d = 0; d < 3; d++) begin
      e_busy = 1; e_rd = 1; e_caddr = 'h15; e_idx = 0;
      if (d == 1) read = 1;
      cyc("R9");
    end
    e_busy = 1; e_rd = 1; e_caddr = 'h15; e_idx = 0;
    ch_ack = 1; ch_rdata = 16'h5A3C; cyc("R8");
    e_dv = 1; e_rdata = 'h5A3C; cyc("R8");
    cyc("R8");

    // R8 analog read acknowledged in its first cycle
    ch_sel = 2; reg_addr = 6'h07;
    read = 1; cyc("R8");
    e_busy = 1; e_rd = 1; e_caddr = 'h07; e_idx = 2;
    ch_ack = 1; ch_rdata = 16'h0F0F; cyc("R8");
    e_dv = 1; e_rdata = 'h0F0F; cyc("R8");
    cyc("R8");

    // R10 read in image mode; R9 request during error pulse
    analog_mode = 0; cont_mode = 1;
    read = 1; cyc("R10");
    e_err = 1; write_all = 1; cyc("R10");
    e_err = 1; cyc("R10");
    cyc("R9");
    cyc("R9");

    // R10 read and write together
    analog_mode = 1;
    read = 1; write_all = 1; cyc("R10");
    e_err = 1; cyc("R10");
    e_err = 1; cyc("R10");
    cyc("R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule